// File: doc/BRIEF.md
# Channel-Indexed Configuration Register Bank

This block is the byte-wide register file that sits behind a serial control port on a four-channel receiver. A separate shift engine turns the serial stream into single-cycle write and read strobes carrying an 8-bit address and 8-bit data. The bank keeps a small set of chip-wide registers plus one private copy of each per-channel register. A mask register chooses which channels' copies a local write lands in. Local reads return the copy of the lowest selected channel.

Per-channel settings and the global pin-function bit are double-buffered. Writes update a pending (master) copy. The live (active) outputs change only when software sets the transfer bit, which copies every pending value to the live copy at once and then clears itself. The channel mask, the output-port enables and the global configuration byte act immediately. A soft-reset bit puts every register, pending and live, back to its default value and then clears itself.

Register addresses: 0x00 global configuration, 0x01 identifier, 0x05 channel mask, 0x08 power mode, 0x0C shuffle, 0xFF transfer. Every other address is unmapped.

Top module: `chan_reg_bank`

## Requirements
- R1: After reset, reads return 0x18 at 0x00, 0x7B at 0x01, 0xCF at 0x05, and 0x00 at 0x08, 0x0C and 0xFF. After reset `port_en` is 2'b11 and `lsb_first`, `pin_standby`, `pwr_mode` and `shuffle_en` are all zero.
- R2: A read strobe loads `rdata` at that clock edge, so the value is visible one cycle later. `rdata` holds its value while no read strobe is present.
- R3: Address 0x01 always reads 0x7B, and writes to it change nothing.
- R4: At 0x05, bits 3:0 are the channel mask (bit 0 is channel 0) and bit 6 and bit 7 enable output ports 0 and 1. Bits 5:4 read as zero. A write takes effect at once, and `port_en` follows bits 7:6.
- R5: 0x00 reads as {0, L, S, 1, 1, S, L, 0}, where L is LSB-first and S is soft-reset. A write sets L when bit 6 or bit 1 is set. The write is ignored unless all four mask bits are set. `lsb_first` shows L at once.
- R6: Writing 0x00 with bit 5 or bit 2 set (mask all ones) makes S read 1 for one cycle. At the next edge every register, pending and live, returns to its default and S clears.
- R7: A write to 0x08 or 0x0C changes the pending copy only of channels whose mask bit is set.
- R8: At 0x08, bits 1:0 are the per-channel power mode (00 normal, 01 full power-down, 10 standby). Bit 5 is the global external-pin function (1 standby, 0 full power-down), and it is written whatever the mask holds.
- R9: At 0x0C, bit 0 is the per-channel shuffle enable. All other bits read zero.
- R10: `pwr_mode`, `shuffle_en` and `pin_standby` change only through a transfer. Writing 0xFF with bit 0 set makes 0xFF read 1 for one cycle. At the next edge all pending values are copied to the live outputs and the bit reads 0 again.
- R11: A read of 0x08 or 0x0C returns the pending copy of the lowest-numbered channel whose mask bit is set. With an empty mask the per-channel field reads zero.
- R12: Reads of unmapped addresses return 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| lsb_first | output | 1 | Serial bit-order select |
| port_en | output | 2 | Output-port enables, ports 0 and 1 |
| pin_standby | output | 1 | Live external-pin function (1 standby) |
| pwr_mode | output | 8 | Live power mode, 2 bits per channel, channel 0 in bits 1:0 |
| shuffle_en | output | 4 | Live shuffle enable per channel |

## Verification
The bench targets writes made through partial or empty channel masks. A bank that ignored the mask would overwrite unselected channels, and one that picked the wrong channel for reads would return another channel's value. It writes the global configuration byte with an incomplete mask and through each mirrored bit, which catches a design that ignores the lock or decodes only one nibble. It checks that live outputs stay frozen until the transfer edge and that the transfer and soft-reset bits read set for exactly one cycle. An off-by-one edge in either self-clearing path would show up as a wrong readback or an early change on the outputs.

// File: rtl/cbk_pkg.sv
package cbk_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_GCFG  = 8'h00;
    localparam logic [ADDR_W-1:0] A_IDENT = 8'h01;
    localparam logic [ADDR_W-1:0] A_MASK  = 8'h05;
    localparam logic [ADDR_W-1:0] A_PWR   = 8'h08;
    localparam logic [ADDR_W-1:0] A_SHUF  = 8'h0C;
    localparam logic [ADDR_W-1:0] A_XFER  = 8'hFF;

    localparam logic [DATA_W-1:0] IDENT_VAL = 8'h7B;

    typedef enum logic [2:0] {
        SEL_GCFG,
        SEL_IDENT,
        SEL_MASK,
        SEL_PWR,
        SEL_SHUF,
        SEL_XFER,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] pwr;
        logic       shuf;
    } chan_cfg_t;

    localparam chan_cfg_t CHAN_DEFAULT = '{pwr: 2'b00, shuf: 1'b0};

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            A_GCFG:  s = SEL_GCFG;
            A_IDENT: s = SEL_IDENT;
            A_MASK:  s = SEL_MASK;
            A_PWR:   s = SEL_PWR;
            A_SHUF:  s = SEL_SHUF;
            A_XFER:  s = SEL_XFER;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Global config byte with its two nibbles mirrored: bits 4:3 fixed high.
    function automatic logic [DATA_W-1:0] mirror_gcfg(input logic lsb, input logic srst);
        return {1'b0, lsb, srst, 1'b1, 1'b1, srst, lsb, 1'b0};
    endfunction

endpackage

// File: rtl/cbk_global_regs.sv
module cbk_global_regs
    import cbk_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int NPORT  = NUM_CH / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [NUM_CH-1:0] chan_mask,
    output logic [NPORT-1:0]  port_q,
    output logic              lsb_q,
    output logic              srst_pend,
    output logic              xfer_pend,
    output logic              pin_mst,
    output logic              pin_act
);

    localparam int PORT_LSB = 6;
    localparam int PIN_BIT  = 5;

    logic mask_full;
    logic xfer_req;
    logic unused_wbit;

    assign mask_full   = &chan_mask;
    assign xfer_req    = wr_en && (sel == SEL_XFER) && wdata[0];
    assign unused_wbit = wdata[4];

    always_ff @(posedge clk) begin
        if (rst || srst_pend) begin
            chan_mask <= '1;
            port_q    <= '1;
            lsb_q     <= 1'b0;
            srst_pend <= 1'b0;
            xfer_pend <= 1'b0;
            pin_mst   <= 1'b0;
            pin_act   <= 1'b0;
        end else begin
            xfer_pend <= xfer_req;
            if (xfer_pend) begin
                pin_act <= pin_mst;
            end
            if (wr_en) begin
                case (sel)
                    SEL_GCFG: begin
                        if (mask_full) begin
                            lsb_q     <= wdata[6] | wdata[1];
                            srst_pend <= wdata[5] | wdata[2];
                        end
                    end
                    SEL_MASK: begin
                        chan_mask <= wdata[NUM_CH-1:0];
                        port_q    <= wdata[PORT_LSB +: NPORT];
                    end
                    SEL_PWR: pin_mst <= wdata[PIN_BIT];
                    default: ;
                endcase
            end
        end
    end

    AST_SRST_RESTORES: assert property (@(posedge clk) disable iff (rst)
        srst_pend |=> (chan_mask == '1 && port_q == '1 && !lsb_q && !srst_pend && !pin_act)); // R6

    AST_GCFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_GCFG && !mask_full && !srst_pend) |=> $stable(lsb_q)); // R5

    AST_XFER_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (xfer_pend && !(wr_en && sel == SEL_XFER)) |=> !xfer_pend); // R10

    AST_PIN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!xfer_pend && !srst_pend) |=> $stable(pin_act)); // R10

endmodule

// File: rtl/cbk_chan_slice.sv
module cbk_chan_slice
    import cbk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      wr_en,
    input  reg_sel_e  sel,
    input  logic [1:0] wfield,
    input  logic      ch_sel,
    input  logic      xfer,
    output chan_cfg_t mst,
    output chan_cfg_t act
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mst <= CHAN_DEFAULT;
            act <= CHAN_DEFAULT;
        end else begin
            if (xfer) begin
                act <= mst;
            end
            if (wr_en && ch_sel) begin
                if (sel == SEL_PWR) begin
                    mst.pwr <= wfield;
                end else if (sel == SEL_SHUF) begin
                    mst.shuf <= wfield[0];
                end
            end
        end
    end

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!xfer && !clr) |=> $stable(act)); // R10

    AST_XFER_COPY: assert property (@(posedge clk) disable iff (rst)
        (xfer && !clr) |=> (act == $past(mst))); // R10

    AST_MASKED_CH: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ch_sel && !clr) |=> $stable(mst)); // R7

endmodule

// File: rtl/cbk_read_mux.sv
module cbk_read_mux
    import cbk_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int NPORT  = NUM_CH / 2
) (
    input  reg_sel_e                       sel,
    input  logic [NUM_CH-1:0]              chan_mask,
    input  logic [NPORT-1:0]               port_q,
    input  logic                           lsb_q,
    input  logic                           srst_pend,
    input  logic                           xfer_pend,
    input  logic                           pin_mst,
    input  chan_cfg_t [NUM_CH-1:0]         mst,
    output logic [DATA_W-1:0]              rd_val
);

    chan_cfg_t low;
    logic [DATA_W-1:0] mask_byte;

    // Lowest selected channel wins: scan from the top so index 0 is last.
    always_comb begin
        low = CHAN_DEFAULT;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (chan_mask[i]) begin
                low = mst[i];
            end
        end
    end

    always_comb begin
        mask_byte = '0;
        mask_byte[NUM_CH-1:0] = chan_mask;
        mask_byte[6 +: NPORT] = port_q;
    end

    always_comb begin
        case (sel)
            SEL_GCFG:  rd_val = mirror_gcfg(lsb_q, srst_pend);
            SEL_IDENT: rd_val = IDENT_VAL;
            SEL_MASK:  rd_val = mask_byte;
            SEL_PWR:   rd_val = {2'b00, pin_mst, 3'b000, low.pwr};
            SEL_SHUF:  rd_val = {7'b0, low.shuf};
            SEL_XFER:  rd_val = {7'b0, xfer_pend};
            default:   rd_val = '0;
        endcase
    end

endmodule

// File: rtl/chan_reg_bank.sv
module chan_reg_bank
    import cbk_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int NPORT  = NUM_CH / 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                lsb_first,
    output logic [NPORT-1:0]    port_en,
    output logic                pin_standby,
    output logic [2*NUM_CH-1:0] pwr_mode,
    output logic [NUM_CH-1:0]   shuffle_en
);

    reg_sel_e               sel;
    logic [NUM_CH-1:0]      chan_mask;
    logic [NPORT-1:0]       port_q;
    logic                   lsb_q;
    logic                   srst_pend;
    logic                   xfer_pend;
    logic                   pin_mst;
    logic                   pin_act;
    chan_cfg_t [NUM_CH-1:0] mst;
    chan_cfg_t [NUM_CH-1:0] act;
    logic [DATA_W-1:0]      rd_val;

    assign sel = decode_addr(addr);

    cbk_global_regs #(.NUM_CH(NUM_CH), .NPORT(NPORT)) u_glob (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .sel       (sel),
        .wdata     (wdata),
        .chan_mask (chan_mask),
        .port_q    (port_q),
        .lsb_q     (lsb_q),
        .srst_pend (srst_pend),
        .xfer_pend (xfer_pend),
        .pin_mst   (pin_mst),
        .pin_act   (pin_act)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        cbk_chan_slice u_slice (
            .clk    (clk),
            .rst    (rst),
            .clr    (srst_pend),
            .wr_en  (wr_en),
            .sel    (sel),
            .wfield (wdata[1:0]),
            .ch_sel (chan_mask[g]),
            .xfer   (xfer_pend),
            .mst    (mst[g]),
            .act    (act[g])
        );
        assign pwr_mode[2*g +: 2] = act[g].pwr;
        assign shuffle_en[g]      = act[g].shuf;
    end

    cbk_read_mux #(.NUM_CH(NUM_CH), .NPORT(NPORT)) u_rmux (
        .sel       (sel),
        .chan_mask (chan_mask),
        .port_q    (port_q),
        .lsb_q     (lsb_q),
        .srst_pend (srst_pend),
        .xfer_pend (xfer_pend),
        .pin_mst   (pin_mst),
        .mst       (mst),
        .rd_val    (rd_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_val;
        end
    end

    assign lsb_first   = lsb_q;
    assign port_en     = port_q;
    assign pin_standby = pin_act;

    AST_IDENT_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_IDENT) |=> (rdata == 8'h7B)); // R3

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_NONE) |=> (rdata == '0)); // R12

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)); // R2

endmodule

// File: tb/chan_reg_bank_tb.sv
module chan_reg_bank_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       lsb_first;
    logic [1:0] port_en;
    logic       pin_standby;
    logic [7:0] pwr_mode;
    logic [3:0] shuffle_en;

    int nvec  = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    chan_reg_bank u_dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .lsb_first   (lsb_first),
        .port_en     (port_en),
        .pin_standby (pin_standby),
        .pwr_mode    (pwr_mode),
        .shuffle_en  (shuffle_en)
    );

    // Entry: {wr[28], req[27:24], addr[23:16], data[15:8], expect[7:0]}
    localparam int NV = 28;
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 4'd1,  8'h00, 8'h00, 8'h18},  // R1
        {1'b0, 4'd1,  8'h01, 8'h00, 8'h7B},  // R1
        {1'b0, 4'd1,  8'h05, 8'h00, 8'hCF},  // R1
        {1'b0, 4'd1,  8'h08, 8'h00, 8'h00},  // R1
        {1'b0, 4'd1,  8'h0C, 8'h00, 8'h00},  // R1
        {1'b0, 4'd1,  8'hFF, 8'h00, 8'h00},  // R1
        {1'b1, 4'd3,  8'h01, 8'h00, 8'h00},  // R3 write ignored
        {1'b0, 4'd3,  8'h01, 8'h00, 8'h7B},  // R3
        {1'b1, 4'd4,  8'h05, 8'h32, 8'h00},  // R4 mask = ch1, bits 5:4 set
        {1'b0, 4'd4,  8'h05, 8'h00, 8'h02},  // R4
        {1'b1, 4'd8,  8'h08, 8'h22, 8'h00},  // R8 ch1 standby, pin standby
        {1'b0, 4'd8,  8'h08, 8'h00, 8'h22},  // R8 R11
        {1'b1, 4'd7,  8'h05, 8'h01, 8'h00},  // R7 select ch0
        {1'b0, 4'd7,  8'h08, 8'h00, 8'h20},  // R7 ch0 untouched
        {1'b1, 4'd9,  8'h0C, 8'hFF, 8'h00},  // R9 ch0 shuffle
        {1'b0, 4'd9,  8'h0C, 8'h00, 8'h01},  // R9
        {1'b1, 4'd11, 8'h05, 8'h0C, 8'h00},  // R11 mask = ch2,ch3
        {1'b0, 4'd11, 8'h0C, 8'h00, 8'h00},  // R11 ch2 is lowest
        {1'b1, 4'd5,  8'h00, 8'h42, 8'h00},  // R5 locked write
        {1'b0, 4'd5,  8'h00, 8'h00, 8'h18},  // R5
        {1'b1, 4'd5,  8'h05, 8'h0F, 8'h00},  // R5 full mask, ports off
        {1'b1, 4'd5,  8'h00, 8'h02, 8'h00},  // R5 via low mirror bit
        {1'b0, 4'd5,  8'h00, 8'h00, 8'h5A},  // R5
        {1'b1, 4'd12, 8'h30, 8'hFF, 8'h00},  // R12
        {1'b0, 4'd12, 8'h30, 8'h00, 8'h00},  // R12
        {1'b0, 4'd12, 8'h05, 8'h00, 8'h0F},  // R12 nothing disturbed
        {1'b1, 4'd11, 8'h05, 8'h00, 8'h00},  // R11 empty mask
        {1'b0, 4'd11, 8'h08, 8'h00, 8'h20}   // R11 local field zero
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp,
                         input string what);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input int req, input logic [7:0] a, input logic [7:0] exp);
        addr  = a;
        rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rdata, exp, $sformatf("read %02h", a));
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 output reset state
        check(1, {6'b0, port_en}, 8'h03, "port_en reset");
        check(1, {3'b0, lsb_first, pin_standby, shuffle_en[2:0]}, 8'h00, "flags reset");
        check(1, pwr_mode, 8'h00, "pwr_mode reset");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][28]) do_write(VEC[i][23:16], VEC[i][15:8]);
            else            do_read(int'(VEC[i][27:24]), VEC[i][23:16], VEC[i][7:0]);
        end

        // R4 R5 immediate outputs
        check(4, {6'b0, port_en}, 8'h00, "port_en after mask write");
        check(5, {7'b0, lsb_first}, 8'h01, "lsb_first set");

        // R10 live outputs frozen before transfer
        check(10, pwr_mode, 8'h00, "pwr_mode before transfer");
        check(10, {3'b0, pin_standby, shuffle_en}, 8'h00, "pin/shuffle before transfer");
        do_write(8'hFF, 8'h01);
        check(10, pwr_mode, 8'h00, "pwr_mode at request edge");
        do_read(10, 8'hFF, 8'h01);
        check(10, pwr_mode, 8'h08, "pwr_mode after transfer");
        check(10, {3'b0, pin_standby, shuffle_en}, 8'h11, "pin/shuffle after transfer");
        do_read(10, 8'hFF, 8'h00);

        // R2 read data holds with no strobe
        do_read(2, 8'h01, 8'h7B);
        addr = 8'h30;
        @(posedge clk);
        @(negedge clk);
        check(2, rdata, 8'h7B, "rdata hold");

        // R6 soft reset through high mirror bit
        do_write(8'h05, 8'h0F);
        do_write(8'h00, 8'h20);
        do_read(6, 8'h00, 8'h3C);
        do_read(6, 8'h00, 8'h18);
        do_read(6, 8'h05, 8'hCF);
        do_read(6, 8'h08, 8'h00);
        check(6, {6'b0, port_en}, 8'h03, "port_en after soft reset");
        check(6, {3'b0, lsb_first, pin_standby, shuffle_en[2:0]}, 8'h00, "flags after soft reset");
        check(6, pwr_mode, 8'h00, "pwr_mode after soft reset");

        finish_run();
    end

endmodule